// File: doc/BRIEF.md
# Quadrature Mouse Motion Counter

This block watches the two phase lines of each axis of a mechanical or optical mouse and keeps a signed count of movement for X and for Y. A pulse is counted when its second phase line rises: if the A line was already high the step is positive, and if the B line was already high the step is negative. Every phase change is seen on the first clock after synchronisation, so no movement is lost to a polling period. Counts saturate rather than wrap.

The host reads both counts through a valid/ready handshake. `rd_valid` is high whenever the block is out of reset. A transfer happens in every cycle where `rd_valid` and `rd_ready` are both high. During that cycle `rd_dx` and `rd_dy` carry the counts, and at the closing clock edge both counts restart from zero. While `rd_ready` stays low, the counts keep accumulating and nothing is lost. This back-pressure has no limit other than saturation. The two button lines are synchronised and passed straight through.

Top module: `mouse_motion_counter`

## Requirements
- R1: For each X pulse where `x_a` rises before `x_b` (A and B are the two phase lines), the X count rises by one when `x_b` rises.
- R2: For each X pulse where `x_b` rises before `x_a`, the X count falls by one when `x_a` rises.
- R3: The Y axis uses `y_a`/`y_b` with the same encoding as R1 and R2, and its count does not depend on X activity.
- R4: A handshake cycle (`rd_valid` and `rd_ready` both high) presents both counts as 8-bit two's complement on `rd_dx`/`rd_dy`, and both counts are zero afterwards.
- R5: While `rd_ready` is low, the counts hold and accumulate across any number of pulses.
- R6: The counts saturate at +127 and -128 and never wrap. A step in the opposite direction leaves saturation normally.
- R7: A step that reaches the counter in the same cycle as a handshake is not lost. The read returns the count from before the step, and the count after the read is +1 or -1.
- R8: When both lines of an axis change in the same synchronised sample, the count does not change.
- R9: Phases that last only one clock each are all counted.
- R10: `btn_state` follows `btn_raw` two clock edges after the change.
- R11: During reset, both counts are zero and `rd_valid` is low. `rd_valid` is high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_a | input | 1 | X axis phase line A, asynchronous |
| x_b | input | 1 | X axis phase line B, asynchronous |
| y_a | input | 1 | Y axis phase line A, asynchronous |
| y_b | input | 1 | Y axis phase line B, asynchronous |
| btn_raw | input | NBTN (2) | Raw button lines |
| rd_ready | input | 1 | Host accepts the counts (read and clear) |
| rd_valid | output | 1 | Counts are available |
| rd_dx | output | CW (8) | Signed X count |
| rd_dy | output | CW (8) | Signed Y count |
| btn_state | output | NBTN (2) | Synchronised buttons |

## Verification
The clear from a handshake and a count step can fall in the same cycle. The bench provokes this by raising the counting phase line exactly two cycles before the handshake cycle, so that the synchronised edge reaches the counter in the same cycle as the clear. The check is passed when that read returns the count from before the step and the next read returns exactly +1 or -1. Saturation at both limits, simultaneous changes on both lines, and one-clock phases are checked through the same scoreboard of reads.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= 1'b0;
        dout[i] <= 1'b0;
      end else begin
        meta[i] <= din[i];
        dout[i] <= meta[i];
      end
    end
  end
endmodule

// File: rtl/qd_decode.sv
module qd_decode
  import mmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,     // {A, B}, synchronised
  output step_e      step
);
  logic [1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 2'b00;
    else        prev <= ab;
  end

  // Count on the second rising line of a pulse.
  always_comb begin
    step = STEP_NONE;
    if (prev == 2'b10 && ab == 2'b11) step = STEP_UP;
    else if (prev == 2'b01 && ab == 2'b11) step = STEP_DOWN;
  end

  // R8: a change of both lines in one sample never yields a step
  assert_both_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((prev ^ ab) == 2'b11) |-> (step == STEP_NONE));
endmodule

// File: rtl/qd_accum.sv
module qd_accum
  import mmc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MAXV = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] MINV = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] base, nxt;

  always_comb begin
    base = clr ? '0 : cnt;
    nxt  = base;
    if (step == STEP_UP && base != MAXV)        nxt = base + ONE;
    else if (step == STEP_DOWN && base != MINV) nxt = base - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step == STEP_NONE) |=> $stable(cnt));
  assert_sat_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == MAXV && step == STEP_UP) |=> (cnt == MAXV));
  assert_sat_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == MINV && step == STEP_DOWN) |=> (cnt == MINV));
  assert_clear_keeps_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (($past(step) == STEP_NONE && cnt == '0) ||
             ($past(step) == STEP_UP   && cnt == ONE) ||
             ($past(step) == STEP_DOWN && cnt == '1)));
endmodule

// File: rtl/mouse_motion_counter.sv
module mouse_motion_counter
  import mmc_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NBTN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_a,
  input  logic            x_b,
  input  logic            y_a,
  input  logic            y_b,
  input  logic [NBTN-1:0] btn_raw,
  input  logic            rd_ready,
  output logic            rd_valid,
  output logic [CW-1:0]   rd_dx,
  output logic [CW-1:0]   rd_dy,
  output logic [NBTN-1:0] btn_state
);
  localparam int NAX = 2;
  localparam int SW  = 2 * NAX + NBTN;

  logic [SW-1:0] raw_vec, sync_vec;
  logic          take;
  logic [1:0]    ab_s [NAX];
  step_e         steps [NAX];
  logic [CW-1:0] cnts [NAX];

  assign raw_vec = {btn_raw, y_a, y_b, x_a, x_b};

  qd_sync #(.W(SW)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (raw_vec), .dout (sync_vec)
  );

  assign take = rd_valid & rd_ready;

  for (genvar k = 0; k < NAX; k++) begin : g_axis
    assign ab_s[k] = sync_vec[2*k +: 2];
    qd_decode u_dec (
      .clk (clk), .rst_n (rst_n), .ab (ab_s[k]), .step (steps[k])
    );
    qd_accum #(.CW(CW)) u_acc (
      .clk (clk), .rst_n (rst_n), .step (steps[k]), .clr (take), .cnt (cnts[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= 1'b1;
  end

  assign rd_dx     = cnts[0];
  assign rd_dy     = cnts[1];
  assign btn_state = sync_vec[SW-1 -: NBTN];

  assert_valid_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_valid);
  assert_btn_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ##2 (btn_state == $past(btn_raw, 2)));
endmodule

// File: tb/mouse_motion_counter_test.sv
module mouse_motion_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_a = 0, x_b = 0, y_a = 0, y_b = 0;
  logic [1:0] btn_raw = 2'b00;
  logic rd_ready = 1'b0;
  logic rd_valid;
  logic [7:0] rd_dx, rd_dy;
  logic [1:0] btn_state;

  int errors = 0;
  int checks = 0;
  int mx = 0, my = 0;
  bit finished = 0;
  logic [15:0] expq [$];
  string tagq [$];

  always #5 clk = ~clk;

  mouse_motion_counter uut (
    .clk(clk), .rst_n(rst_n), .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b),
    .btn_raw(btn_raw), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_dx(rd_dx), .rd_dy(rd_dy), .btn_state(btn_state)
  );

  function automatic int sat(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic set_line(input int axis, input bit lb, input logic v);
    if (axis == 0) begin if (lb) x_b = v; else x_a = v; end
    else           begin if (lb) y_b = v; else y_a = v; end
  endtask

  // One pulse: fwd means A rises first
  task automatic pulse(input int axis, input bit fwd, input int hold);
    bit first = fwd ? 1'b0 : 1'b1;
    set_line(axis, first, 1); cyc(hold);
    set_line(axis, ~first, 1); cyc(hold);
    set_line(axis, first, 0); cyc(hold);
    set_line(axis, ~first, 0); cyc(hold);
    if (axis == 0) mx = sat(mx + (fwd ? 1 : -1));
    else           my = sat(my + (fwd ? 1 : -1));
  endtask

  // Driver: push expected read, then perform the handshake
  task automatic do_read(input string tag);
    cyc(4);
    expq.push_back({mx[7:0], my[7:0]});
    tagq.push_back(tag);
    rd_ready = 1; cyc(1); rd_ready = 0;
    mx = 0; my = 0;
    cyc(1);
  endtask

  // Monitor: compares each handshake with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid && rd_ready) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4: unexpected read actual=%h expected=none", {rd_dx, rd_dy});
        end else begin
          string t = tagq.pop_front();
          check(t, {rd_dx, rd_dy}, expq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R11 reset state
    check("R11 reset counts", {rd_dx, rd_dy}, 16'h0000);
    check("R11 valid low in reset", {15'd0, rd_valid}, 16'd0);
    rst_n = 1; cyc(1);
    check("R11 valid after reset", {15'd0, rd_valid}, 16'd1);

    // R1 forward X pulses
    repeat (3) pulse(0, 1, 3);
    do_read("R1 forward x");
    // R2 reverse X pulses
    repeat (4) pulse(0, 0, 3);
    do_read("R2 reverse x");
    // R3 Y axis with X activity interleaved
    repeat (2) pulse(1, 0, 3);
    pulse(0, 1, 3);
    repeat (5) pulse(1, 1, 2);
    do_read("R3 y independent");
    // R4 counts zero after the read
    do_read("R4 zero after clear");
    // R5 hold across idle gap
    repeat (3) pulse(0, 1, 3);
    cyc(40);
    repeat (2) pulse(0, 1, 3);
    do_read("R5 accumulate without read");
    // R9 one-clock phases
    repeat (10) pulse(0, 1, 1);
    repeat (7) pulse(1, 0, 1);
    do_read("R9 one clock phases");
    // R6 saturation both ways and recovery
    repeat (130) pulse(0, 1, 1);
    repeat (130) pulse(1, 0, 1);
    do_read("R6 saturate");
    repeat (130) pulse(0, 1, 1);
    pulse(0, 0, 1);
    repeat (130) pulse(1, 0, 1);
    pulse(1, 1, 1);
    do_read("R6 leave saturation");
    // R8 both lines change together
    x_a = 1; x_b = 1; cyc(3);
    x_a = 0; x_b = 0; cyc(3);
    y_a = 1; y_b = 1; cyc(3);
    y_a = 0; y_b = 0; cyc(3);
    do_read("R8 simultaneous change");
    // R7 step lands in the handshake cycle (forward, from 5)
    repeat (5) pulse(0, 1, 2);
    cyc(4);
    x_a = 1; cyc(3);
    x_b = 1;            // counting edge
    cyc(2);
    expq.push_back({mx[7:0], my[7:0]}); tagq.push_back("R7 read before step");
    rd_ready = 1; cyc(1); rd_ready = 0;
    mx = 1; my = 0;
    x_a = 0; cyc(2); x_b = 0; cyc(2);
    do_read("R7 step kept after clear");
    // R7 reverse, on Y with nonzero count
    repeat (3) pulse(1, 1, 2);
    cyc(4);
    y_b = 1; cyc(3);
    y_a = 1;
    cyc(2);
    expq.push_back({mx[7:0], my[7:0]}); tagq.push_back("R7 read before y step");
    rd_ready = 1; cyc(1); rd_ready = 0;
    mx = 0; my = -1;
    y_b = 0; cyc(2); y_a = 0; cyc(2);
    do_read("R7 y step kept after clear");
    // R10 buttons
    btn_raw = 2'b10; cyc(1);
    check("R10 button not yet", {14'd0, btn_state}, 16'd0);
    cyc(1);
    check("R10 button follows", {14'd0, btn_state}, 16'd2);
    btn_raw = 2'b01; cyc(2);
    check("R10 button follows 2", {14'd0, btn_state}, 16'd1);

    cyc(3);
    if (expq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R4: actual=%0d pending reads expected=0", expq.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule